// File: doc/BRIEF.md
# Chip Interrupt Priority Controller

This block collects interrupt requests from the peripherals of a chip, qualifies them with an enable register, and presents one prioritised request to a processor. Two 16-bit registers hold the state. The request register holds raised requests. The enable register holds per-source enables and a master enable. Software writes both registers through a set/clear write format, and peripherals raise requests with one-cycle pulses.

Each cycle the block forms the pending set and picks the highest-numbered pending source. It translates that source to a 3-bit processor level through a fixed table and compares the level with the processor's current priority mask. When the level is above the mask, the block raises a request and presents the level, the winning source index and the address where the processor fetches the handler vector. If the processor is stopped at that moment, a wake pulse is also issued.

A small controller tracks the request with three states:
- `ST_QUIET`: no request is raised.
- `ST_WAKE`: a request is raised and the wake pulse is driven.
- `ST_HOLD`: a request is raised and no wake pulse is driven.

The controller changes state as follows:
- `ST_QUIET` or `ST_HOLD` goes to `ST_WAKE` when a request qualifies and the processor is stopped.
- `ST_QUIET` or `ST_HOLD` goes to `ST_HOLD` when a request qualifies and the processor is running.
- `ST_WAKE` goes to `ST_HOLD` while a request still qualifies.
- Any state goes to `ST_QUIET` when no request qualifies.

Top module: `intr_prio_ctrl`

## Requirements
- R1: A synchronous reset clears both registers, `irq_valid`, `irq_level`, `irq_source`, `vector_addr` and `wake_pulse` to zero.
- R2: A register write with data bit 15 at 1 sets every register bit in 14:0 whose data bit is 1. Bit 15 of each register always reads 0.
- R3: A register write with data bit 15 at 0 clears every register bit in 14:0 whose data bit is 1. Bits written as 0 keep their value in both write forms.
- R4: A pulse on `periph_req[i]` sets request bit i in the same clock edge as a write. It takes precedence over a clear of that bit written at the same edge.
- R5: While enable bit 14 (master enable) is 0, `irq_valid` is 0 from the next clock edge on, whatever the other bits hold.
- R6: The pending set is the request register ANDed with the enable register. Only pending bits 13..0 are sources, and the highest-numbered pending bit wins. Request bits 14 and 15 never cause a request.
- R7: The winning source maps to `irq_level` as follows: sources 0-2 give 1, source 3 gives 2, sources 4-6 give 3, sources 7-10 give 4, sources 11-12 give 5, and source 13 gives 6. `irq_source` carries the winning index.
- R8: A request is raised only when the mapped level is strictly greater than `cpu_ipl_mask`, the interrupt mask field taken from bits 10:8 of the processor status word. A mask of 7 blocks every source.
- R9: `vector_addr` equals `vbr` + 0x60 + 4 × `irq_level` while `irq_valid` is 1.
- R10: All outputs are registered and follow a register update or an input change by one clock edge. While `irq_valid` is 0, `irq_level`, `irq_source` and `vector_addr` are 0.
- R11: `wake_pulse` is 1 for exactly one cycle when a request is raised while `cpu_stopped` is 1. That happens on entry to `ST_WAKE` from `ST_QUIET` or `ST_HOLD`. The pulse is never 1 without `irq_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_wr_en | input | 1 | Write strobe for the request register |
| req_wr_data | input | 16 | Request write data; bit 15 selects set (1) or clear (0) |
| ena_wr_en | input | 1 | Write strobe for the enable register |
| ena_wr_data | input | 16 | Enable write data; bit 15 selects set (1) or clear (0) |
| periph_req | input | 14 | One-cycle request pulses from peripherals |
| cpu_ipl_mask | input | 3 | Processor priority mask (status word bits 10:8) |
| vbr | input | 32 | Vector base address |
| cpu_stopped | input | 1 | Processor is in its stopped state |
| req_reg | output | 16 | Current request register |
| ena_reg | output | 16 | Current enable register |
| irq_valid | output | 1 | Interrupt request to the processor |
| irq_level | output | 3 | Requested processor level |
| irq_source | output | 4 | Index of the winning source |
| vector_addr | output | 32 | Vector fetch address |
| wake_pulse | output | 1 | One-cycle wake request to a stopped processor |

## Verification
The main function is tried in three ways:
- Single-source walks over all fourteen sources separate the level table entries from one another and from the index output.
- Multi-source patterns, including sources that share a level, show whether the scan picks the highest index rather than the highest level or the lowest index.
- Mask sweeps around each source's level separate a strict comparison from a greater-or-equal one.

Further patterns probe the register controls and the wake behaviour:
- A set-only pattern on request bit 14 and a cleared master enable show whether the control bits leak into the scan.
- A clear written together with a peripheral pulse on the same bit shows which one has precedence.
- Holding `cpu_stopped` high across a raised request shows whether the wake pulse is a single cycle or a level.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_WAKE  = 2'd1,
        ST_HOLD  = 2'd2
    } ctl_state_t;

    // Fixed source-to-level table (index 14/15 entries kept for completeness)
    function automatic logic [2:0] src_to_level(input logic [3:0] src);
        logic [2:0] lv;
        unique case (src)
            4'd0, 4'd1, 4'd2:          lv = 3'd1;
            4'd3:                      lv = 3'd2;
            4'd4, 4'd5, 4'd6:          lv = 3'd3;
            4'd7, 4'd8, 4'd9, 4'd10:   lv = 3'd4;
            4'd11, 4'd12:              lv = 3'd5;
            4'd13, 4'd14:              lv = 3'd6;
            default:                   lv = 3'd7;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/intr_bit_regs.sv
// Set/clear register: bit REG_W-1 of write data selects set or clear,
// external set pulses OR in after the write.
module intr_bit_regs #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-2:0] set_in,
    output logic [REG_W-1:0] q
);
    localparam int DATA_W = REG_W - 1;

    logic [DATA_W-1:0] bits_q;
    logic              set_mode;

    assign set_mode = wr_data[REG_W-1];

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic nxt;
        always_comb begin
            nxt = bits_q[b];
            if (wr_en && wr_data[b]) begin
                nxt = set_mode;
            end
            if (set_in[b]) begin
                nxt = 1'b1;
            end
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[b] <= 1'b0;
            end else begin
                bits_q[b] <= nxt;
            end
        end
    end

    assign q = {1'b0, bits_q};

endmodule

// File: rtl/intr_prio_scan.sv
// Highest-index-wins priority encoder over N pending bits.
module intr_prio_scan #(
    parameter int N     = 14,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intr_level_map.sv
// Source index to processor level translation.
module intr_level_map #(
    parameter int IDX_W = 4,
    parameter int LVL_W = 3
) (
    input  logic [IDX_W-1:0] src,
    output logic [LVL_W-1:0] level
);
    import intr_prio_pkg::*;

    logic [3:0] src4;
    assign src4  = 4'(src);
    assign level = LVL_W'(src_to_level(src4));
endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl #(
    parameter int          REG_W      = 16,
    parameter int          SRC_N      = 14,
    parameter int          MASTER_BIT = 14,
    parameter int          LVL_W      = 3,
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] VEC_BASE   = 32'h60,
    parameter int          IDX_W      = $clog2(SRC_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_wr_en,
    input  logic [REG_W-1:0]  req_wr_data,
    input  logic              ena_wr_en,
    input  logic [REG_W-1:0]  ena_wr_data,
    input  logic [SRC_N-1:0]  periph_req,
    input  logic [LVL_W-1:0]  cpu_ipl_mask,
    input  logic [ADDR_W-1:0] vbr,
    input  logic              cpu_stopped,
    output logic [REG_W-1:0]  req_reg,
    output logic [REG_W-1:0]  ena_reg,
    output logic              irq_valid,
    output logic [LVL_W-1:0]  irq_level,
    output logic [IDX_W-1:0]  irq_source,
    output logic [ADDR_W-1:0] vector_addr,
    output logic              wake_pulse
);
    import intr_prio_pkg::*;

    localparam int PAD_W = REG_W - 1 - SRC_N;

    // ---------------- registers ----------------
    logic [REG_W-2:0] req_set;
    logic [REG_W-2:0] ena_set;

    if (PAD_W > 0) begin : g_pad
        assign req_set = {{PAD_W{1'b0}}, periph_req};
    end else begin : g_nopad
        assign req_set = periph_req[REG_W-2:0];
    end
    assign ena_set = '0;

    intr_bit_regs #(.REG_W(REG_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req_wr_en),
        .wr_data (req_wr_data),
        .set_in  (req_set),
        .q       (req_reg)
    );

    intr_bit_regs #(.REG_W(REG_W)) u_ena (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ena_wr_en),
        .wr_data (ena_wr_data),
        .set_in  (ena_set),
        .q       (ena_reg)
    );

    // ---------------- scan and map ----------------
    logic [SRC_N-1:0] pend;
    logic             any_pend;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic             hit;

    assign pend = req_reg[SRC_N-1:0] & ena_reg[SRC_N-1:0];

    intr_prio_scan #(.N(SRC_N), .IDX_W(IDX_W)) u_scan (
        .pend  (pend),
        .found (any_pend),
        .idx   (win_idx)
    );

    intr_level_map #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_map (
        .src   (win_idx),
        .level (win_lvl)
    );

    assign hit = ena_reg[MASTER_BIT] && any_pend && (win_lvl > cpu_ipl_mask);

    // ---------------- controller ----------------
    ctl_state_t state_q;
    ctl_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (hit) begin
                    state_d = cpu_stopped ? ST_WAKE : ST_HOLD;
                end
            end
            ST_WAKE: begin
                state_d = hit ? ST_HOLD : ST_QUIET;
            end
            ST_HOLD: begin
                if (!hit) begin
                    state_d = ST_QUIET;
                end else if (cpu_stopped) begin
                    state_d = ST_WAKE;
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- registered outputs ----------------
    logic [ADDR_W-1:0] vec_d;
    assign vec_d = vbr + ADDR_W'(VEC_BASE) + (ADDR_W'(win_lvl) << 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid   <= 1'b0;
            irq_level   <= '0;
            irq_source  <= '0;
            vector_addr <= '0;
            wake_pulse  <= 1'b0;
        end else begin
            irq_valid   <= hit;
            irq_level   <= hit ? win_lvl : '0;
            irq_source  <= hit ? win_idx : '0;
            vector_addr <= hit ? vec_d : '0;
            wake_pulse  <= (state_d == ST_WAKE);
        end
    end

endmodule

// File: rtl/intr_prio_chk.sv
module intr_prio_chk #(
    parameter int          REG_W      = 16,
    parameter int          SRC_N      = 14,
    parameter int          MASTER_BIT = 14,
    parameter int          LVL_W      = 3,
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] VEC_BASE   = 32'h60,
    parameter int          IDX_W      = $clog2(SRC_N)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_wr_en,
    input logic [REG_W-1:0]  req_wr_data,
    input logic [LVL_W-1:0]  cpu_ipl_mask,
    input logic [ADDR_W-1:0] vbr,
    input logic [REG_W-1:0]  ena_reg,
    input logic [REG_W-1:0]  req_reg,
    input logic              irq_valid,
    input logic [LVL_W-1:0]  irq_level,
    input logic [IDX_W-1:0]  irq_source,
    input logic [ADDR_W-1:0] vector_addr,
    input logic              wake_pulse
);
    AST_SET_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_wr_en && req_wr_data[REG_W-1]) |=>
        ((req_reg[REG_W-2:0] & $past(req_wr_data[REG_W-2:0])) == $past(req_wr_data[REG_W-2:0]))); // R2

    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (rst)
        !ena_reg[MASTER_BIT] |=> !irq_valid); // R5

    AST_SRC_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (int'(irq_source) < SRC_N)); // R6

    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level != '0)); // R7

    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level > $past(cpu_ipl_mask))); // R8

    AST_VECTOR: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (vector_addr == $past(vbr) + ADDR_W'(VEC_BASE) + (ADDR_W'(irq_level) << 2))); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_level == '0 && irq_source == '0 && vector_addr == '0)); // R10

    AST_WAKE_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> irq_valid); // R11

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse); // R11
endmodule

bind intr_prio_ctrl intr_prio_chk #(
    .REG_W(REG_W), .SRC_N(SRC_N), .MASTER_BIT(MASTER_BIT), .LVL_W(LVL_W),
    .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_wr_en    (req_wr_en),
    .req_wr_data  (req_wr_data),
    .cpu_ipl_mask (cpu_ipl_mask),
    .vbr          (vbr),
    .ena_reg      (ena_reg),
    .req_reg      (req_reg),
    .irq_valid    (irq_valid),
    .irq_level    (irq_level),
    .irq_source   (irq_source),
    .vector_addr  (vector_addr),
    .wake_pulse   (wake_pulse)
);

// File: tb/sim_intr_prio_ctrl.sv
`timescale 1ns/1ps
module sim_intr_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_wr_en = 1'b0;
    logic [15:0] req_wr_data = '0;
    logic        ena_wr_en = 1'b0;
    logic [15:0] ena_wr_data = '0;
    logic [13:0] periph_req = '0;
    logic [2:0]  cpu_ipl_mask = '0;
    logic [31:0] vbr = 32'h0000_1000;
    logic        cpu_stopped = 1'b0;
    logic [15:0] req_reg, ena_reg;
    logic        irq_valid, wake_pulse;
    logic [2:0]  irq_level;
    logic [3:0]  irq_source;
    logic [31:0] vector_addr;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit finished = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    intr_prio_ctrl u0 (
        .clk(clk), .rst(rst),
        .req_wr_en(req_wr_en), .req_wr_data(req_wr_data),
        .ena_wr_en(ena_wr_en), .ena_wr_data(ena_wr_data),
        .periph_req(periph_req), .cpu_ipl_mask(cpu_ipl_mask),
        .vbr(vbr), .cpu_stopped(cpu_stopped),
        .req_reg(req_reg), .ena_reg(ena_reg),
        .irq_valid(irq_valid), .irq_level(irq_level),
        .irq_source(irq_source), .vector_addr(vector_addr),
        .wake_pulse(wake_pulse)
    );

    // ---------------- behavioural reference model ----------------
    int m_req, m_ena, m_valid, m_level, m_src, m_vec, m_wake, m_st;

    function automatic int ref_level(int s);
        if (s <= 2) return 1;
        if (s == 3) return 2;
        if (s <= 6) return 3;
        if (s <= 10) return 4;
        if (s <= 12) return 5;
        return 6;
    endfunction

    function automatic int apply_wr(int cur, int data);
        int low = data & 32'h7FFF;
        if ((data & 32'h8000) != 0) return cur | low;
        return cur & ~low;
    endfunction

    always @(posedge clk) begin
        int win, lvl, hit, nreq, nena, nst;
        started <= 1;
        if (rst) begin
            m_req <= 0; m_ena <= 0; m_valid <= 0; m_level <= 0;
            m_src <= 0; m_vec <= 0; m_wake <= 0; m_st <= 0;
        end else begin
            win = -1;
            for (int i = 13; i >= 0; i--) begin
                if (win < 0 && ((m_req & m_ena) >> i) % 2 == 1) win = i;
            end
            lvl = (win >= 0) ? ref_level(win) : 0;
            hit = ((m_ena & 32'h4000) != 0 && win >= 0 && lvl > int'(cpu_ipl_mask)) ? 1 : 0;
            if (hit == 0) nst = 0;
            else if (m_st == 1) nst = 2;
            else nst = cpu_stopped ? 1 : 2;
            nreq = m_req;
            if (req_wr_en) nreq = apply_wr(nreq, int'(req_wr_data));
            nreq = nreq | int'(periph_req);
            nena = m_ena;
            if (ena_wr_en) nena = apply_wr(nena, int'(ena_wr_data));
            m_req   <= nreq;
            m_ena   <= nena;
            m_st    <= nst;
            m_valid <= hit;
            m_level <= hit ? lvl : 0;
            m_src   <= hit ? win : 0;
            m_vec   <= hit ? int'(vbr) + 96 + 4 * lvl : 0;
            m_wake  <= (nst == 1) ? 1 : 0;
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            check(phase, "req_reg", int'(req_reg), m_req);
            check(phase, "ena_reg", int'(ena_reg), m_ena);
            check(phase, "irq_valid", int'(irq_valid), m_valid);
            check(phase, "irq_level", int'(irq_level), m_level);
            check(phase, "irq_source", int'(irq_source), m_src);
            check(phase, "vector_addr", int'(vector_addr), m_vec);
            check(phase, "wake_pulse", int'(wake_pulse), m_wake);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_req(logic [15:0] d);
        req_wr_en = 1'b1; req_wr_data = d;
        tick();
        req_wr_en = 1'b0; req_wr_data = '0;
    endtask

    task automatic wr_ena(logic [15:0] d);
        ena_wr_en = 1'b1; ena_wr_data = d;
        tick();
        ena_wr_en = 1'b0; ena_wr_data = '0;
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        rst = 1'b0;
        // R1: reset state
        phase = "R1";
        check("R1", "irq_valid", int'(irq_valid), 0);
        check("R1", "req_reg", int'(req_reg), 0);
        check("R1", "vector_addr", int'(vector_addr), 0);

        // R2: set write of enable (sources 13 and 0 plus master)
        phase = "R2";
        wr_ena(16'hE001);
        check("R2", "ena_reg", int'(ena_reg), 32'h6001);
        // R10: request write, output one edge later
        phase = "R10";
        wr_req(16'h8001);
        check("R10", "req_reg", int'(req_reg), 1);
        check("R10", "irq_valid early", int'(irq_valid), 0);
        tick();
        check("R10", "irq_valid", int'(irq_valid), 1);
        check("R7", "level src0", int'(irq_level), 1);
        check("R9", "vector", int'(vector_addr), 32'h1064);

        // R6: higher source wins
        phase = "R6";
        periph_req = 14'h2000; tick(); periph_req = '0; tick();
        check("R6", "source", int'(irq_source), 13);
        check("R7", "level src13", int'(irq_level), 6);
        check("R9", "vector 6", int'(vector_addr), 32'h1078);

        // R8: strict mask comparison
        phase = "R8";
        cpu_ipl_mask = 3'd6; tick();
        check("R8", "mask6 valid", int'(irq_valid), 0);
        cpu_ipl_mask = 3'd5; tick();
        check("R8", "mask5 valid", int'(irq_valid), 1);
        cpu_ipl_mask = 3'd7; tick();
        check("R8", "mask7 valid", int'(irq_valid), 0);
        cpu_ipl_mask = 3'd0;

        // R5 and R3: clearing master only
        phase = "R5";
        wr_ena(16'h4000);
        check("R3", "ena after clear", int'(ena_reg), 32'h2001);
        tick();
        check("R5", "master off", int'(irq_valid), 0);
        wr_ena(16'hC000);

        // R4: periph set beats simultaneous clear
        phase = "R4";
        req_wr_en = 1'b1; req_wr_data = 16'h2001; periph_req = 14'h0001;
        tick();
        req_wr_en = 1'b0; req_wr_data = '0; periph_req = '0;
        check("R4", "req_reg", int'(req_reg), 1);

        // R6: request bit 14 is not a source
        phase = "R6";
        wr_req(16'h7FFF);
        wr_req(16'hC000);
        tick();
        check("R6", "bit14 alone", int'(irq_valid), 0);
        wr_req(16'h4000);

        // R7: walk every source alone with all enables on
        phase = "R7";
        wr_ena(16'hFFFF);
        for (int s = 0; s < 14; s++) begin
            wr_req(16'h8000 | (16'h1 << s));
            tick();
            check("R7", "walk source", int'(irq_source), s);
            check("R7", "walk level", int'(irq_level),
                  (s < 3) ? 1 : (s == 3) ? 2 : (s < 7) ? 3 : (s < 11) ? 4 : (s < 13) ? 5 : 6);
            wr_req(16'h7FFF);
        end
        // R6: same-level pair, higher index wins
        wr_req(16'h8180);
        tick();
        check("R6", "pair 7/8", int'(irq_source), 8);
        wr_req(16'h7FFF);
        tick();

        // R11: wake on raise while stopped
        phase = "R11";
        cpu_stopped = 1'b1;
        wr_req(16'h8010);
        check("R11", "wake before", int'(wake_pulse), 0);
        tick();
        check("R11", "wake pulse", int'(wake_pulse), 1);
        cpu_stopped = 1'b0;
        tick();
        check("R11", "wake ends", int'(wake_pulse), 0);
        check("R11", "irq held", int'(irq_valid), 1);
        wr_req(16'h7FFF);
        tick();
        // varied vbr and mask patterns
        phase = "R9";
        vbr = 32'hABCD_0000;
        cpu_ipl_mask = 3'd2;
        wr_req(16'h8A08);
        tick();
        check("R9", "vector 5", int'(vector_addr), 32'hABCD_0074);
        tick();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule